// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block is a 32-pin general-purpose I/O bank with a small register file reached through a flat address, write data and write enable interface. Reads are combinational. Software sets the direction of each pin and the value driven on output pins. It reads back the synchronized level of every pin. It picks how each input pin raises an interrupt.

Every pin passes through a two-flop synchronizer and then a detector. The detector watches for a low level, a high level, a rising edge or a falling edge. An override register switches any pin to detect both edges. A detected event sets a sticky flag, which software clears by writing 1 to it. Flags that pass an enable mask are OR-reduced into one interrupt line for pins 0–15 and one for pins 16–31. A parameter adds a dedicated line for each of the eight lowest pins, so software can route those eight separately.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every writable register reads 0, the flag register reads 0, and `pin_oe`, `pin_out` and all interrupt outputs are 0.
- R2: The sense configuration for pins 0–15 is at offset 0x0C, with pin n in bits [2n+1:2n]. Code 01 selects high-level detection, so a flag sets on every cycle the input is high.
- R3: Sense code 00 selects low-level detection. With the reset configuration and all pins held low, every flag becomes set.
- R4: The sense configuration for pins 16–31 is at offset 0x10, with pin n in bits [2(n-16)+1:2(n-16)]. Code 10 detects rising edges only and code 11 detects falling edges only.
- R5: A 1 in the both-edge register at offset 0x1C makes that pin detect both edges, whatever its sense code says. A held level then raises no further event.
- R6: The flag register is at offset 0x18. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A detection in the same cycle wins over a clear, so a persisting level keeps its flag set.
- R7: The enable register is at offset 0x14. Flags set whatever the enable bits say, but only enabled flags reach the interrupt outputs.
- R8: `irq_lo` is the OR of the enabled flags of pins 0–15, and `irq_hi` is the OR of the enabled flags of pins 16–31.
- R9: With per-pin outputs enabled, `irq_pin[n]` is the enabled flag of pin n, for n = 0–7.
- R10: The direction register is at offset 0x04, where a 1 marks an output. An output pin raises no event. `pin_oe` shows the direction register and `pin_out` shows the data register at offset 0x00.
- R11: Offset 0x08 reads the synchronized pin level, which follows `pin_in` after two clock edges.
- R12: A pin change made before clock edge k shows in its flag, and in the interrupt outputs, just after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register |
| wr_data | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_data | output | DATA_W | Combinational read data for `addr` |
| pin_in | input | DATA_W | Raw pad inputs |
| pin_out | output | DATA_W | Output data to the pads |
| pin_oe | output | DATA_W | Output enable for each pad |
| irq_lo | output | 1 | Combined interrupt for pins 0–15 |
| irq_hi | output | 1 | Combined interrupt for pins 16–31 |
| irq_pin | output | DIRECT_IRQS | Dedicated interrupt lines for the low pins |

## Verification
Register writes take effect at the edge that samples `wr_en`, and reads are valid in the same cycle. The pin-state register lags `pin_in` by two edges. A pin event reaches its flag, and the outputs derived from it, on the third edge after the change. The bench changes inputs just after a falling edge and counts falling edges before it queues an expected value. It probes both one edge early, where the old value must still show, and exactly on time. A clear or a mask change is checked on the falling edge that follows its write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_HIGH = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_FALL = 2'b11
   } sense_e;

   localparam int unsigned OFS_DATA     = 'h00;
   localparam int unsigned OFS_DIR      = 'h04;
   localparam int unsigned OFS_STATE    = 'h08;
   localparam int unsigned OFS_SENSE_LO = 'h0C;
   localparam int unsigned OFS_SENSE_HI = 'h10;
   localparam int unsigned OFS_ENABLE   = 'h14;
   localparam int unsigned OFS_FLAG     = 'h18;
   localparam int unsigned OFS_BOTH     = 'h1C;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stage1;
   logic [W-1:0] stage2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage1 <= '0;
         stage2 <= '0;
      end else begin
         stage1 <= d;
         stage2 <= stage1;
      end
   end

   assign q = stage2;

   // settle counter, only used to keep the lag check off pre-reset history
   logic [1:0] age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age <= '0;
      else if (age != 2'd3) age <= age + 2'd1;
   end

   p_sync_lag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (age == 2'd3) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
   import gpio_irq_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] level,
   input  logic [W-1:0] dir,
   input  logic [31:0]  sense_lo,
   input  logic [31:0]  sense_hi,
   input  logic [W-1:0] both,
   output logic [W-1:0] evt
);

   localparam int HALF = W / 2;

   logic [W-1:0] prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= level;
   end

   for (genvar i = 0; i < W; i++) begin : g_pin
      sense_e code;
      logic   rise;
      logic   fall;
      logic   hit;

      if (i < HALF) begin : g_lo
         assign code = sense_e'(sense_lo[2*i +: 2]);
      end else begin : g_hi
         assign code = sense_e'(sense_hi[2*(i-HALF) +: 2]);
      end

      assign rise = level[i] & ~prev[i];
      assign fall = ~level[i] & prev[i];
      assign hit  = both[i]              ? (rise | fall) :
                    (code == SENSE_LOW)  ? ~level[i]     :
                    (code == SENSE_HIGH) ? level[i]      :
                    (code == SENSE_RISE) ? rise          : fall;
      assign evt[i] = hit & ~dir[i];
   end

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
   parameter int W       = 32,
   parameter int DIRECT  = 8,
   parameter bit PER_PIN = 1'b1
) (
   input  logic [W-1:0]      pend,
   output logic              irq_lo,
   output logic              irq_hi,
   output logic [DIRECT-1:0] irq_pin
);

   localparam int HALF = W / 2;

   assign irq_lo = |pend[HALF-1:0];
   assign irq_hi = |pend[W-1:HALF];

   if (PER_PIN) begin : g_direct
      assign irq_pin = pend[DIRECT-1:0];
   end else begin : g_no_direct
      assign irq_pin = '0;
   end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
   import gpio_irq_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 5,
   parameter int DIRECT_IRQS = 8,
   parameter bit PER_PIN_IRQ = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic                   wr_en,
   output logic [DATA_W-1:0]      rd_data,
   input  logic [DATA_W-1:0]      pin_in,
   output logic [DATA_W-1:0]      pin_out,
   output logic [DATA_W-1:0]      pin_oe,
   output logic                   irq_lo,
   output logic                   irq_hi,
   output logic [DIRECT_IRQS-1:0] irq_pin
);

   localparam logic [ADDR_W-1:0] A_DATA     = ADDR_W'(OFS_DATA);
   localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFS_DIR);
   localparam logic [ADDR_W-1:0] A_STATE    = ADDR_W'(OFS_STATE);
   localparam logic [ADDR_W-1:0] A_SENSE_LO = ADDR_W'(OFS_SENSE_LO);
   localparam logic [ADDR_W-1:0] A_SENSE_HI = ADDR_W'(OFS_SENSE_HI);
   localparam logic [ADDR_W-1:0] A_ENABLE   = ADDR_W'(OFS_ENABLE);
   localparam logic [ADDR_W-1:0] A_FLAG     = ADDR_W'(OFS_FLAG);
   localparam logic [ADDR_W-1:0] A_BOTH     = ADDR_W'(OFS_BOTH);
   localparam int                HALF       = DATA_W / 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("gpio_irq_bank: DATA_W must be 32 (two 16-pin sense words)");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("gpio_irq_bank: ADDR_W must reach offset 0x1C");
   end
   if (DIRECT_IRQS < 1 || DIRECT_IRQS > HALF) begin : g_bad_direct
      $error("gpio_irq_bank: DIRECT_IRQS must lie within the low half");
   end

   logic [DATA_W-1:0] out_q, dir_q, en_q, flag_q, both_q;
   logic [31:0]       sense_lo_q, sense_hi_q;
   logic [DATA_W-1:0] level, evt, clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q      <= '0;
         dir_q      <= '0;
         en_q       <= '0;
         both_q     <= '0;
         sense_lo_q <= '0;
         sense_hi_q <= '0;
      end else if (wr_en) begin
         if (addr == A_DATA)     out_q      <= wr_data;
         if (addr == A_DIR)      dir_q      <= wr_data;
         if (addr == A_ENABLE)   en_q       <= wr_data;
         if (addr == A_BOTH)     both_q     <= wr_data;
         if (addr == A_SENSE_LO) sense_lo_q <= wr_data;
         if (addr == A_SENSE_HI) sense_hi_q <= wr_data;
      end
   end

   assign clr = (wr_en && addr == A_FLAG) ? wr_data : '0;

   // a fresh event wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= '0;
      else        flag_q <= (flag_q & ~clr) | evt;
   end

   gpio_irq_sync #(.W(DATA_W)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (level)
   );

   gpio_irq_detect #(.W(DATA_W)) u_detect (
      .clk      (clk),
      .rst_n    (rst_n),
      .level    (level),
      .dir      (dir_q),
      .sense_lo (sense_lo_q),
      .sense_hi (sense_hi_q),
      .both     (both_q),
      .evt      (evt)
   );

   gpio_irq_combine #(
      .W       (DATA_W),
      .DIRECT  (DIRECT_IRQS),
      .PER_PIN (PER_PIN_IRQ)
   ) u_combine (
      .pend    (flag_q & en_q),
      .irq_lo  (irq_lo),
      .irq_hi  (irq_hi),
      .irq_pin (irq_pin)
   );

   always_comb begin
      case (addr)
         A_DATA:     rd_data = out_q;
         A_DIR:      rd_data = dir_q;
         A_STATE:    rd_data = level;
         A_SENSE_LO: rd_data = sense_lo_q;
         A_SENSE_HI: rd_data = sense_hi_q;
         A_ENABLE:   rd_data = en_q;
         A_FLAG:     rd_data = flag_q;
         A_BOTH:     rd_data = both_q;
         default:    rd_data = '0;
      endcase
   end

   assign pin_out = out_q;
   assign pin_oe  = dir_q;

   p_flag_needs_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~$past(flag_q) & ~$past(evt)) == '0);

   p_output_pin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q & ~$past(flag_q) & $past(dir_q)) == '0);

   p_direct_in_combined_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_pin) |-> irq_lo);

   p_mask_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |-> (!irq_lo && !irq_hi));

endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/100ps
module gpio_irq_bank_tb;

   localparam logic [4:0] A_DATA = 5'h00, A_DIR = 5'h04, A_STATE = 5'h08,
                          A_SLO = 5'h0C, A_SHI = 5'h10, A_EN = 5'h14,
                          A_FLAG = 5'h18, A_BOTH = 5'h1C;
   localparam int K_RD = 0, K_LO = 1, K_HI = 2, K_PIN = 3, K_OUT = 4, K_OE = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wr_data = '0;
   logic        wr_en = 1'b0;
   logic [31:0] rd_data, pin_out, pin_oe;
   logic [31:0] pins = '0;
   logic        irq_lo, irq_hi;
   logic [7:0]  irq_pin;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   gpio_irq_bank u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_data (wr_data),
      .wr_en   (wr_en),
      .rd_data (rd_data),
      .pin_in  (pins),
      .pin_out (pin_out),
      .pin_oe  (pin_oe),
      .irq_lo  (irq_lo),
      .irq_hi  (irq_hi),
      .irq_pin (irq_pin)
   );

   typedef struct {
      int          kind;
      logic [31:0] exp;
      string       req;
   } exp_t;

   exp_t q[$];
   event chk_ev;

   function automatic logic [31:0] observe(int kind);
      case (kind)
         K_RD:    return rd_data;
         K_LO:    return {31'b0, irq_lo};
         K_HI:    return {31'b0, irq_hi};
         K_PIN:   return {24'b0, irq_pin};
         K_OUT:   return pin_out;
         default: return pin_oe;
      endcase
   endfunction

   // monitor: pops expectations and compares against the live outputs
   initial begin
      forever begin
         exp_t e;
         logic [31:0] act;
         @(chk_ev);
         while (q.size() > 0) begin
            e = q.pop_front();
            act = observe(e.kind);
            checks++;
            if (act !== e.exp) begin
               errors++;
               $display("FAIL %s actual %h expected %h", e.req, act, e.exp);
            end
         end
      end
   end

   task automatic expect_out(int kind, logic [31:0] exp, string req);
      q.push_back('{kind: kind, exp: exp, req: req});
      ->chk_ev;
      #0.1;
   endtask

   task automatic expect_rd(logic [4:0] a, logic [31:0] exp, string req);
      addr = a;
      #0.1;
      expect_out(K_RD, exp, req);
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [4:0] a, logic [31:0] d);
      addr = a;
      wr_data = d;
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      #0.1;
      // R1 reset state
      expect_rd(A_DATA, 32'h0, "R1 data");
      expect_rd(A_DIR,  32'h0, "R1 dir");
      expect_rd(A_SLO,  32'h0, "R1 sense_lo");
      expect_rd(A_SHI,  32'h0, "R1 sense_hi");
      expect_rd(A_EN,   32'h0, "R1 enable");
      expect_rd(A_FLAG, 32'h0, "R1 flag");
      expect_rd(A_BOTH, 32'h0, "R1 both");
      expect_out(K_OE, 32'h0, "R1 oe");
      tick(1);
      expect_out(K_LO, 32'h0, "R1 irq_lo");
      expect_out(K_HI, 32'h0, "R1 irq_hi");
      expect_out(K_PIN, 32'h0, "R1 irq_pin");

      // R3 low level by default sets all flags, R7 masked outputs stay low
      tick(3);
      expect_rd(A_FLAG, 32'hFFFF_FFFF, "R3 low level flags");
      expect_out(K_LO, 32'h0, "R7 masked lo");

      // move every pin to high level, then clear
      wr(A_SLO, 32'h5555_5555);
      wr(A_SHI, 32'h5555_5555);
      tick(2);
      wr(A_FLAG, 32'hFFFF_FFFF);
      expect_rd(A_FLAG, 32'h0, "R6 clear all");

      // R2 high level on pin 5 with enable, R12 latency
      wr(A_EN, 32'h0000_0020);
      pins[5] = 1'b1;
      tick(2);
      expect_rd(A_FLAG, 32'h0, "R12 not before third edge");
      tick(1);
      expect_rd(A_FLAG, 32'h0000_0020, "R2 high level flag");
      expect_out(K_LO, 32'h1, "R8 irq_lo");
      expect_out(K_PIN, 32'h20, "R9 irq_pin5");
      expect_out(K_HI, 32'h0, "R8 irq_hi quiet");
      wr(A_FLAG, 32'h0000_0020);
      expect_rd(A_FLAG, 32'h0000_0020, "R6 level persists over clear");
      wr(A_FLAG, 32'h0);
      expect_rd(A_FLAG, 32'h0000_0020, "R6 zero write no effect");
      pins[5] = 1'b0;
      tick(3);
      wr(A_FLAG, 32'h0000_0020);
      expect_rd(A_FLAG, 32'h0, "R6 clear after level gone");
      expect_out(K_LO, 32'h0, "R8 irq_lo drops");

      // R4 rising edge on pin 18
      wr(A_EN, 32'hFFFF_FFFF);
      wr(A_SHI, 32'h5555_5565);
      pins[18] = 1'b1;
      tick(3);
      expect_rd(A_FLAG, 32'h0004_0000, "R4 rising flag");
      expect_out(K_HI, 32'h1, "R8 irq_hi");
      expect_out(K_LO, 32'h0, "R8 irq_lo quiet");
      wr(A_FLAG, 32'h0004_0000);
      expect_rd(A_FLAG, 32'h0, "R4 edge does not persist");
      pins[18] = 1'b0;
      tick(4);
      expect_rd(A_FLAG, 32'h0, "R4 falling ignored in rise mode");

      // R4 falling edge on pin 9
      wr(A_SLO, 32'h555D_5555);
      pins[9] = 1'b1;
      tick(4);
      expect_rd(A_FLAG, 32'h0, "R4 rising ignored in fall mode");
      pins[9] = 1'b0;
      tick(3);
      expect_rd(A_FLAG, 32'h0000_0200, "R4 falling flag");
      expect_out(K_LO, 32'h1, "R8 irq_lo pin9");
      expect_out(K_PIN, 32'h0, "R9 pin9 not direct");
      wr(A_FLAG, 32'h0000_0200);

      // R5 both-edge override on pin 26 (sense code high level)
      wr(A_BOTH, 32'h0400_0000);
      pins[26] = 1'b1;
      tick(3);
      expect_rd(A_FLAG, 32'h0400_0000, "R5 rise under override");
      wr(A_FLAG, 32'h0400_0000);
      tick(2);
      expect_rd(A_FLAG, 32'h0, "R5 held level no event");
      pins[26] = 1'b0;
      tick(3);
      expect_rd(A_FLAG, 32'h0400_0000, "R5 fall under override");
      wr(A_FLAG, 32'h0400_0000);
      expect_rd(A_BOTH, 32'h0400_0000, "R5 readback");

      // R10 direction and output data
      wr(A_DIR, 32'h0000_0100);
      expect_out(K_OE, 32'h0000_0100, "R10 oe");
      wr(A_DATA, 32'h1234_5678);
      expect_out(K_OUT, 32'h1234_5678, "R10 pin_out");
      expect_rd(A_DATA, 32'h1234_5678, "R10 data readback");
      pins[8] = 1'b1;
      tick(4);
      expect_rd(A_FLAG, 32'h0, "R10 output pin no event");
      wr(A_DIR, 32'h0);
      tick(1);
      expect_rd(A_FLAG, 32'h0000_0100, "R10 input again detects");
      pins[8] = 1'b0;
      tick(3);
      wr(A_FLAG, 32'hFFFF_FFFF);

      // R11 pin state lag
      wr(A_EN, 32'h0);
      pins = 32'hDEAD_BEEF;
      tick(1);
      expect_rd(A_STATE, 32'h0, "R11 one edge still old");
      tick(1);
      expect_rd(A_STATE, 32'hDEAD_BEEF, "R11 two edges new");

      // R7 masked flags still set, R8/R9 selection
      tick(2);
      expect_out(K_LO, 32'h0, "R7 masked lo");
      expect_out(K_HI, 32'h0, "R7 masked hi");
      expect_out(K_PIN, 32'h0, "R7 masked pin");
      expect_rd(A_FLAG, 32'hDEAD_BCEF, "R7 flags set while masked");
      wr(A_EN, 32'h0000_0001);
      expect_out(K_LO, 32'h1, "R8 lo from pin0");
      expect_out(K_PIN, 32'h1, "R9 pin0 direct");
      expect_out(K_HI, 32'h0, "R8 hi masked");
      wr(A_EN, 32'h8000_0000);
      expect_out(K_HI, 32'h1, "R8 hi from pin31");
      expect_out(K_LO, 32'h0, "R8 lo masked");

      tick(1);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule